// File: doc/BRIEF.md
# Ripple-Down Sample FIFO with Status/Control Word

This block stores up to eight finished conversion results. Each result is a 12-bit two's-complement value with a one-bit out-of-range marker. Every new result goes into the lowest free slot. A processor always reads the oldest result from slot 0. After each such read, every stored entry moves down one slot. The block runs on the converter clock. A conversion-done strobe from the converter logic writes into it, and a simple synchronous bus reads and writes it.

One address bit selects between the sample queue and a 12-bit status/control word. Writing the word programs four things: an almost-full level, a mask for the almost-full flag, a bus permission that applies while the converter is busy, and a whole-block soft reset. Reading the word returns the almost-full flag, the programmed level, the mask, a sticky overrun flag, a sticky out-of-range summary, the empty flag, the out-of-range marker of slot 0, and an occupancy code. An active-low almost-full output can be used as an interrupt once a chosen number of results has been gathered.

Top module: `rippleSampleFifo`

## Requirements
- R1: A queue read (busAddr=0) returns the slot-0 data, and then each entry moves down one slot, so results come out oldest first. The queue holds at most eight entries.
- R2: A status/control write (busAddr=1) takes its fields from these bits: bits 10:8 are the almost-full level code, bit 7 is the flag mask, and bit 5 is the busy-time bus permission. Bits 10:8 and bit 7 read back from the same positions.
- R3: When a conversion ends and the resulting entry count is at least the level code plus one, almostFullN goes low on the following cycle and status bit 11 reads 0. For example, code 011 triggers at four entries.
- R4: almostFullN returns high after a queue read that leaves fewer entries than the level code plus one. It also returns high after a write with bit 7 set, and it stays high for as long as bit 7 is 1.
- R5: A result that arrives while the queue is full and no read happens in that cycle is dropped. Status bit 6 then reads 1 and stays 1 until a reset.
- R6: A queue read while the queue is empty moves nothing and returns the last word held in slot 0. Status bit 4 reads 1 when the queue is empty.
- R7: A low rstN sets every slot to 0x800 with its marker clear, and it clears all control fields. After reset the status word reads 0x810 and almostFullN is 1.
- R8: Writing a 1 to status bit 6 has the same effect as R7 on the next cycle.
- R9: A status read moves no entries and changes no state.
- R10: If a result arrives in the same cycle as a queue read, the read entry is removed and the new entry is stored, and the count stays the same. This also holds when the queue is full, and nothing is lost.
- R11: Status bit 5 reads 1 once any stored entry has carried the out-of-range marker, and it clears when the queue becomes empty. Status bit 3 reads the slot-0 marker while the queue is not empty.
- R12: While convBusy is 1 and the bus permission bit is 0, busDrive stays 0 and reads and writes have no effect.
- R13: Status bits 2:0 read the entry count minus one, and read 000 when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convDone | input | 1 | One-cycle strobe: a conversion result is ready |
| convOor | input | 1 | Out-of-range marker of the result |
| convData | input | 12 | Two's-complement result |
| convBusy | input | 1 | Converter is moving from track to hold |
| busSel | input | 1 | Bus access select, active high |
| busAddr | input | 1 | 0 selects the queue, 1 selects the status/control word |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 12 | Write data for the status/control word |
| busRdData | output | 12 | Read data: slot 0 or the status word |
| busDrive | output | 1 | Read data is valid to drive onto the bus |
| almostFullN | output | 1 | Active-low almost-full flag |

## Verification
A conversion result can arrive in the same clock as a queue read. The design must then shift and store in that one cycle. The bench provokes this with the queue partly full and again with it exactly full. It judges the outcome by the word returned at that moment, by the unchanged occupancy code in a later status read, and by the complete ordered drain, which must end with the new word and contain nothing that was dropped earlier. Two other coincidences are also checked: a result arriving while the almost-full flag is masked, and a bus access arriving while the converter is busy.

// File: rtl/sfifoPkg.sv
package sfifoPkg;

  // Control-to-datapath strobes for one clock
  typedef struct packed {
    logic doShift;  // move every entry down one slot
    logic doLoad;   // write the incoming result into the one-hot slot
    logic doClear;  // soft reset of all slots
  } fifoStrobeT;

  // Status/control word bit positions (software decodes these)
  localparam int unsigned AF_BIT    = 11;
  localparam int unsigned LVL_LO    = 8;
  localparam int unsigned MASK_BIT  = 7;
  localparam int unsigned OVR_BIT   = 6;
  localparam int unsigned OOR_BIT   = 5;
  localparam int unsigned EMPTY_BIT = 4;
  localparam int unsigned HEAD_BIT  = 3;

endpackage

// File: rtl/sfifoStore.sv
module sfifoStore
  import sfifoPkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strobe,
  input  logic [DEPTH-1:0]  loadOneHot,
  input  logic [DATA_W-1:0] inData,
  input  logic              inOor,
  output logic [DATA_W-1:0] headData,
  output logic              headOor
);

  localparam logic [DATA_W-1:0] RESET_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] slotData [DEPTH];
  logic              slotOor  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [DATA_W-1:0] aboveData;
    logic              aboveOor;
    if (i == DEPTH - 1) begin : gTop
      assign aboveData = slotData[i];
      assign aboveOor  = slotOor[i];
    end else begin : gMid
      assign aboveData = slotData[i+1];
      assign aboveOor  = slotOor[i+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[i] <= RESET_WORD;
        slotOor[i]  <= 1'b0;
      end else if (strobe.doClear) begin
        slotData[i] <= RESET_WORD;
        slotOor[i]  <= 1'b0;
      end else if (strobe.doLoad && loadOneHot[i]) begin
        slotData[i] <= inData;
        slotOor[i]  <= inOor;
      end else if (strobe.doShift) begin
        slotData[i] <= aboveData;
        slotOor[i]  <= aboveOor;
      end
    end
  end

  assign headData = slotData[0];
  assign headOor  = slotOor[0];

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadOneHot)) else $error("load select not one-hot"); // R1

  AST_CLEAR_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClear |=> (headData == RESET_WORD && !headOor)) else $error("clear missed"); // R8

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doShift && !strobe.doClear && !(strobe.doLoad && loadOneHot[0]))
      |=> (headData == $past(slotData[1]))) else $error("shift lost"); // R1

endmodule

// File: rtl/sfifoCtrl.sv
module sfifoCtrl
  import sfifoPkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              convOor,
  input  logic              convBusy,
  input  logic              busSel,
  input  logic              busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              headOor,
  output fifoStrobeT        strobe,
  output logic [DEPTH-1:0]  loadOneHot,
  output logic [DATA_W-1:0] statusWord,
  output logic              busDrive,
  output logic              almostFullN
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] wordCnt, nextCnt, afLevel, loadPos;
  logic [IDX_W-1:0] afCode;
  logic afMask, allowBusy, afFlag, ovrFlag, oorSticky;
  logic accessOk, fifoRd, regWr, softRst;
  logic popEff, pushKeep, overrunEv, isEmpty, isFull;
  logic [EMPTY_BIT+1:0] unusedWrBits;

  assign unusedWrBits = {busWrData[AF_BIT], busWrData[EMPTY_BIT:0]};

  always_comb begin
    accessOk  = busSel & (~convBusy | allowBusy);
    fifoRd    = accessOk & busRd & ~busAddr;
    regWr     = accessOk & busWr & busAddr;
    softRst   = regWr & busWrData[OVR_BIT];
    isEmpty   = (wordCnt == '0);
    isFull    = (wordCnt == FULL_CNT);
    popEff    = fifoRd & ~isEmpty;
    pushKeep  = convDone & (~isFull | popEff);
    overrunEv = convDone & isFull & ~popEff;
    afLevel   = CNT_W'(afCode) + ONE_CNT;
    loadPos   = popEff ? (wordCnt - ONE_CNT) : wordCnt;
    nextCnt   = wordCnt + CNT_W'(pushKeep) - CNT_W'(popEff);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSel
    assign loadOneHot[i] = pushKeep & (loadPos == CNT_W'(i));
  end

  always_comb begin
    strobe.doShift = popEff & (wordCnt > ONE_CNT);
    strobe.doLoad  = pushKeep;
    strobe.doClear = softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt   <= '0;
      afCode    <= '0;
      afMask    <= 1'b0;
      allowBusy <= 1'b0;
      afFlag    <= 1'b0;
      ovrFlag   <= 1'b0;
      oorSticky <= 1'b0;
    end else if (softRst) begin
      wordCnt   <= '0;
      afCode    <= '0;
      afMask    <= 1'b0;
      allowBusy <= 1'b0;
      afFlag    <= 1'b0;
      ovrFlag   <= 1'b0;
      oorSticky <= 1'b0;
    end else begin
      wordCnt <= nextCnt;
      if (regWr) begin
        afCode    <= busWrData[LVL_LO +: IDX_W];
        afMask    <= busWrData[MASK_BIT];
        allowBusy <= busWrData[OOR_BIT];
      end
      if (regWr && busWrData[MASK_BIT])        afFlag <= 1'b0;
      else if (afMask)                          afFlag <= 1'b0;
      else if (convDone)                        afFlag <= (nextCnt >= afLevel);
      else if (popEff && (nextCnt < afLevel))   afFlag <= 1'b0;
      if (overrunEv) ovrFlag <= 1'b1;
      if (pushKeep && convOor)               oorSticky <= 1'b1;
      else if (popEff && (nextCnt == '0))    oorSticky <= 1'b0;
    end
  end

  always_comb begin
    statusWord                      = '0;
    statusWord[AF_BIT]              = ~afFlag;
    statusWord[LVL_LO +: IDX_W]     = afCode;
    statusWord[MASK_BIT]            = afMask;
    statusWord[OVR_BIT]             = ovrFlag;
    statusWord[OOR_BIT]             = oorSticky;
    statusWord[EMPTY_BIT]           = isEmpty;
    statusWord[HEAD_BIT]            = headOor & ~isEmpty;
    statusWord[IDX_W-1:0]           = isEmpty ? '0 : IDX_W'(wordCnt - ONE_CNT);
  end

  assign busDrive    = accessOk & busRd;
  assign almostFullN = ~afFlag;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= FULL_CNT) else $error("count past depth"); // R5

  AST_NO_SHIFT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !strobe.doShift) else $error("shift while empty"); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !softRst) |=> ovrFlag) else $error("overrun dropped"); // R5

  AST_AF_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    afMask |=> almostFullN) else $error("flag raised while masked"); // R4

  AST_PAIR_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (pushKeep && popEff && !softRst) |=> $stable(wordCnt)) else $error("pair moved count"); // R10

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !allowBusy) |-> !busDrive) else $error("drive while busy"); // R12

endmodule

// File: rtl/rippleSampleFifo.sv
module rippleSampleFifo
  import sfifoPkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              convOor,
  input  logic [DATA_W-1:0] convData,
  input  logic              convBusy,
  input  logic              busSel,
  input  logic              busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busDrive,
  output logic              almostFullN
);

  fifoStrobeT        strobe;
  logic [DEPTH-1:0]  loadOneHot;
  logic [DATA_W-1:0] statusWord, headData;
  logic              headOor;

  sfifoCtrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convDone   (convDone),
    .convOor    (convOor),
    .convBusy   (convBusy),
    .busSel     (busSel),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .busWr      (busWr),
    .busWrData  (busWrData),
    .headOor    (headOor),
    .strobe     (strobe),
    .loadOneHot (loadOneHot),
    .statusWord (statusWord),
    .busDrive   (busDrive),
    .almostFullN(almostFullN)
  );

  sfifoStore #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadOneHot(loadOneHot),
    .inData    (convData),
    .inOor     (convOor),
    .headData  (headData),
    .headOor   (headOor)
  );

  assign busRdData = busAddr ? statusWord : headData;

endmodule

// File: tb/test_rippleSampleFifo.sv
module test_rippleSampleFifo;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 1'b0, convOor = 1'b0, convBusy = 1'b0;
  logic [11:0] convData = '0;
  logic busSel = 1'b0, busAddr = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [11:0] busWrData = '0;
  logic [11:0] busRdData;
  logic busDrive, almostFullN;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [11:0] obsRd;
  logic obsAf, obsDrv;

  always #5 clk = ~clk; // 10 ns period

  rippleSampleFifo i_rippleSampleFifo (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convOor(convOor),
    .convData(convData), .convBusy(convBusy), .busSel(busSel),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .busDrive(busDrive), .almostFullN(almostFullN)
  );

  typedef struct packed {
    logic        push;
    logic        oor;
    logic [11:0] pdata;
    logic        rd;
    logic        wr;
    logic        addr;
    logic [11:0] wdata;
    logic [11:0] expRd;
    logic        expAf;
  } vecT;

  localparam vecT TBL [16] = '{
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1, 12'h000, 12'h810, 1'b1}, // R7 R9
    '{1'b0,1'b0,12'h000, 1'b0,1'b1,1'b1, 12'h320, 12'h810, 1'b1}, // R2
    '{1'b1,1'b0,12'h123, 1'b0,1'b0,1'b0, 12'h000, 12'h800, 1'b1}, // R1
    '{1'b1,1'b0,12'h7FF, 1'b1,1'b0,1'b1, 12'h000, 12'hB00, 1'b1}, // R13
    '{1'b1,1'b1,12'hF00, 1'b0,1'b0,1'b0, 12'h000, 12'h123, 1'b1}, // R1
    '{1'b1,1'b0,12'h001, 1'b1,1'b0,1'b1, 12'h000, 12'hB22, 1'b1}, // R11 R13
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1, 12'h000, 12'h323, 1'b0}, // R3 R2
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0, 12'h000, 12'h123, 1'b0}, // R1 R4
    '{1'b1,1'b0,12'h456, 1'b1,1'b0,1'b0, 12'h000, 12'h7FF, 1'b1}, // R10
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1, 12'h000, 12'hB2A, 1'b1}, // R11
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0, 12'h000, 12'hF00, 1'b1}, // R1
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0, 12'h000, 12'h001, 1'b1}, // R1
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0, 12'h000, 12'h456, 1'b1}, // R1
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1, 12'h000, 12'hB10, 1'b1}, // R6 R11
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0, 12'h000, 12'h456, 1'b1}, // R6
    '{1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1, 12'h000, 12'hB10, 1'b1}  // R9 R6
  };

  function automatic string tagOf(int i);
    case (i)
      0: return "R7 R9";   1: return "R2";      2: return "R1";
      3: return "R13";     4: return "R1";      5: return "R11 R13";
      6: return "R3 R2";   7: return "R1 R4";   8: return "R10";
      9: return "R11";     13: return "R6 R11"; 14: return "R6";
      15: return "R9 R6";  default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one clock of stimulus; outputs are sampled before the active edge
  task automatic cyc(input logic push, input logic oor, input logic [11:0] pd,
                     input logic rd, input logic wr, input logic addr,
                     input logic [11:0] wd, input logic busy);
    @(negedge clk);
    convDone = push; convOor = oor; convData = pd;
    busSel = rd | wr; busRd = rd; busWr = wr; busAddr = addr;
    busWrData = wd; convBusy = busy;
    #3;
    obsRd = busRdData; obsAf = almostFullN; obsDrv = busDrive;
    @(posedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset flag", {11'b0, almostFullN}, 12'h001);
    check("R7 reset head", busRdData, 12'h800);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) begin
      vecT v;
      v = TBL[i];
      cyc(v.push, v.oor, v.pdata, v.rd, v.wr, v.addr, v.wdata, 1'b0);
      check({tagOf(i), " data"}, obsRd, v.expRd);
      check({tagOf(i), " flag"}, {11'b0, obsAf}, {11'b0, v.expAf});
      check({tagOf(i), " drive"}, {11'b0, obsDrv}, {11'b0, v.rd});
    end

    // Flag mask and re-enable
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h0A0, 1'b0);
    cyc(1'b1, 1'b0, 12'h100, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    idle();
    check("R4 masked push", {11'b0, obsAf}, 12'h001);
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h020, 1'b0);
    idle();
    check("R4 unmask no eval", {11'b0, obsAf}, 12'h001);
    cyc(1'b1, 1'b0, 12'h101, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    idle();
    check("R3 level 0 set", {11'b0, obsAf}, 12'h000);
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h0A0, 1'b0);
    idle();
    check("R4 mask write clears", {11'b0, obsAf}, 12'h001);

    // Fill, overrun, and pair at full
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h020, 1'b0);
    for (int k = 0; k < 6; k++)
      cyc(1'b1, 1'b0, 12'h102 + 12'(k), 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    cyc(1'b1, 1'b0, 12'hABC, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R5 R13 overrun status", obsRd, 12'h047);
    cyc(1'b1, 1'b0, 12'h200, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0);
    check("R10 pair at full data", obsRd, 12'h100);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R10 pair at full count", obsRd, 12'h047);
    for (int k = 0; k < 8; k++) begin
      logic [11:0] exp;
      exp = (k == 7) ? 12'h200 : 12'h101 + 12'(k);
      cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0);
      check("R5 R1 drain order", obsRd, exp);
    end
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R5 R6 drained status", obsRd, 12'h850);

    // Soft reset and busy gating
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h040, 1'b0);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R8 soft reset status", obsRd, 12'h810);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0);
    check("R8 soft reset head", obsRd, 12'h800);
    cyc(1'b1, 1'b0, 12'h333, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1);
    check("R12 blocked drive", {11'b0, obsDrv}, 12'h000);
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h0A0, 1'b1);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R12 blocked access no effect", obsRd, 12'h000);
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b1, 12'h020, 1'b0);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1);
    check("R12 permitted drive", {11'b0, obsDrv}, 12'h001);
    check("R12 permitted data", obsRd, 12'h333);

    // Hard reset mid-run
    cyc(1'b1, 1'b0, 12'h444, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
    idle();
    check("R3 flag before reset", {11'b0, obsAf}, 12'h000);
    @(negedge clk);
    rstN = 1'b0;
    #2;
    check("R7 flag in reset", {11'b0, almostFullN}, 12'h001);
    @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    check("R7 status after reset", obsRd, 12'h810);
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0);
    check("R7 head after reset", obsRd, 12'h800);

    finish();
  end

endmodule